// File: doc/BRIEF.md
# Packed Colour Lookup Table

This block holds a 256-colour lookup table for a display pipeline. The table is kept as 128 words of 32 bits, and each word carries two 16-bit colour entries. Software fills and inspects the table through a simple word-wide register port that answers in a fixed 512-byte address window. Accesses outside that window change nothing and read back as zero.

On the pixel side an 8-bit colour index goes in and a 24-bit RGB colour comes out one clock later. Each entry stores three 5-bit components and one spare flag bit. The flag bit has no effect on the colour. Each component is widened to 8 bits by placing three zero bits below it. A byte-order control input swaps the red and blue positions of the output so that panels wired in either order can be driven.

The table contents are not reset. Only the two output registers are cleared. The pixel port reads the table before a write on the same clock edge takes effect.

Top module: `palette_lut`

## Requirements
- R1: A bus write with byte address 0x200 + 4*n (n = 0..127) stores the full 32-bit data word as table word n. A later bus read of that address returns exactly that value on busRdata in the cycle after the read strobe.
- R2: A bus access with address below 0x200 or at or above 0x400 is outside the window. Such a write leaves every table word unchanged. Such a read sets busRdata to zero in the following cycle.
- R3: Pixel index 2*n selects bits [15:0] of table word n, and index 2*n+1 selects bits [31:16].
- R4: In a 16-bit entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. The output is pixRgb = {red, green, blue} with red at [23:16] and blue at [7:0]. Each 8-bit output component equals the 5-bit field shifted left by three, so its low three bits are zero.
- R5: Bit 15 of an entry has no effect on pixRgb.
- R6: When bgrSel is 1, the red and blue bytes of pixRgb trade places: blue is at [23:16] and red at [7:0]. Green stays at [15:8].
- R7: pixRgb shows the colour for the pixIdx and bgrSel values sampled at the previous rising clock edge. It holds steady while those inputs and the addressed table word do not change.
- R8: When a bus write and a lookup of the same word share a clock edge, the lookup returns the colour from before the write. The following lookup returns the new colour.
- R9: While rst is high, pixRgb and busRdata are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| busWr | input | 1 | Bus write strobe |
| busRd | input | 1 | Bus read strobe |
| busAddr | input | 12 | Bus byte address |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Registered bus read data |
| pixIdx | input | 8 | Pixel colour index |
| bgrSel | input | 1 | Swap red and blue on the output when 1 |
| pixRgb | output | 24 | Registered 24-bit colour |

## Verification
The bench builds the block with its default parameters: 128 table words, a 12-bit address and a window starting at 0x200. With these values every one of the 256 entries can be written, read back and looked up with exact expected colours. The addresses just outside the window, 0x1FC and 0x400, are single legal bus addresses, so both edges of the window can be probed directly. The small table also lets the same-edge write and lookup case be aimed at a chosen word at either end of the table.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int unsigned DefAddrW = 12;
  localparam int unsigned DefBase  = 32'h200;
  localparam int unsigned DefWords = 128;
  localparam int unsigned DefWordW = 32;
  localparam int unsigned DefCompW = 5;
  localparam int unsigned DefOutW  = 8;

  // Strobes from the address decoder to the storage datapath.
  typedef struct packed {
    logic wrEn;   // write, already qualified by the window
    logic rdEn;   // read request, any address
    logic inWin;  // address falls inside the table window
  } palCmd_t;
endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palette_pkg::*;
#(
  parameter int unsigned ADDR_W    = DefAddrW,
  parameter int unsigned BASE_ADDR = DefBase,
  parameter int unsigned WORDS     = DefWords,
  localparam int unsigned IDX_W    = $clog2(WORDS),
  localparam int unsigned PIX_W    = IDX_W + 1
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PIX_W-1:0]  pixIdx,
  output palCmd_t           cmd,
  output logic [IDX_W-1:0]  busIdx,
  output logic [IDX_W-1:0]  pixWord,
  output logic              pixHigh
);
  localparam logic [ADDR_W-1:0] LoAddr = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] HiAddr = ADDR_W'(BASE_ADDR + WORDS * 4 - 1);

  logic [ADDR_W-1:0] offs;
  logic              inWin;
  logic              unusedOffs;

  assign offs  = busAddr - LoAddr;
  assign inWin = (busAddr >= LoAddr) && (busAddr <= HiAddr);

  always_comb begin
    cmd.wrEn  = busWr & inWin;
    cmd.rdEn  = busRd;
    cmd.inWin = inWin;
  end

  // Word index drops the byte lane bits.
  assign busIdx     = offs[IDX_W+1:2];
  assign unusedOffs = ^{offs[ADDR_W-1:IDX_W+2], offs[1:0]};

  // Upper index bits pick the word, the lowest bit picks the half.
  assign pixWord = pixIdx[PIX_W-1:1];
  assign pixHigh = pixIdx[0];
endmodule

// File: rtl/palette_expand.sv
module palette_expand #(
  parameter int unsigned ENTRY_W = 16,
  parameter int unsigned COMP_W  = 5,
  parameter int unsigned OUT_W   = 8,
  localparam int unsigned SHIFT  = OUT_W - COMP_W
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic               bgr,
  output logic [3*OUT_W-1:0] rgb
);
  logic [OUT_W-1:0] comp [3];
  logic             unusedFlag;

  for (genvar c = 0; c < 3; c++) begin : g_comp
    assign comp[c] = {entry[c*COMP_W +: COMP_W], {SHIFT{1'b0}}};
  end

  // Bits above the three fields (intensity flag) do not reach the output.
  assign unusedFlag = ^entry[ENTRY_W-1:3*COMP_W];

  assign rgb = bgr ? {comp[2], comp[1], comp[0]}
                   : {comp[0], comp[1], comp[2]};
endmodule

// File: rtl/palette_datapath.sv
module palette_datapath
  import palette_pkg::*;
#(
  parameter int unsigned WORDS    = DefWords,
  parameter int unsigned WORD_W   = DefWordW,
  parameter int unsigned COMP_W   = DefCompW,
  parameter int unsigned OUT_W    = DefOutW,
  localparam int unsigned IDX_W   = $clog2(WORDS),
  localparam int unsigned ENTRY_W = WORD_W / 2
) (
  input  logic               clk,
  input  logic               rst,
  input  palCmd_t            cmd,
  input  logic [IDX_W-1:0]   busIdx,
  input  logic [WORD_W-1:0]  busWdata,
  output logic [WORD_W-1:0]  busRdata,
  input  logic [IDX_W-1:0]   pixWord,
  input  logic               pixHigh,
  input  logic               bgrSel,
  output logic [3*OUT_W-1:0] pixRgb
);
  logic [WORD_W-1:0]  store [WORDS];
  logic [WORD_W-1:0]  pixData;
  logic [ENTRY_W-1:0] entrySel;
  logic [ENTRY_W-1:0] entryQ;
  logic               bgrQ;

  // Table storage, not reset.
  always_ff @(posedge clk) begin
    if (cmd.wrEn) store[busIdx] <= busWdata;
  end

  // Bus readback register.
  always_ff @(posedge clk) begin
    if (rst) begin
      busRdata <= '0;
    end else if (cmd.rdEn) begin
      busRdata <= cmd.inWin ? store[busIdx] : '0;
    end
  end

  // Pixel lookup: read the word before any same-edge write lands.
  assign pixData  = store[pixWord];
  assign entrySel = pixHigh ? pixData[WORD_W-1:ENTRY_W] : pixData[ENTRY_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      entryQ <= '0;
      bgrQ   <= 1'b0;
    end else begin
      entryQ <= entrySel;
      bgrQ   <= bgrSel;
    end
  end

  palette_expand #(
    .ENTRY_W(ENTRY_W),
    .COMP_W (COMP_W),
    .OUT_W  (OUT_W)
  ) u_expand (
    .entry(entryQ),
    .bgr  (bgrQ),
    .rgb  (pixRgb)
  );
endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_pkg::*;
#(
  parameter int unsigned ADDR_W    = DefAddrW,
  parameter int unsigned BASE_ADDR = DefBase,
  parameter int unsigned WORDS     = DefWords,
  parameter int unsigned WORD_W    = DefWordW,
  parameter int unsigned COMP_W    = DefCompW,
  parameter int unsigned OUT_W     = DefOutW,
  localparam int unsigned IDX_W    = $clog2(WORDS),
  localparam int unsigned PIX_W    = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [WORD_W-1:0]  busWdata,
  output logic [WORD_W-1:0]  busRdata,
  input  logic [PIX_W-1:0]   pixIdx,
  input  logic               bgrSel,
  output logic [3*OUT_W-1:0] pixRgb
);
  palCmd_t          cmd;
  logic [IDX_W-1:0] busIdx;
  logic [IDX_W-1:0] pixWord;
  logic             pixHigh;

  palette_ctrl #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .WORDS    (WORDS)
  ) u_ctrl (
    .busWr  (busWr),
    .busRd  (busRd),
    .busAddr(busAddr),
    .pixIdx (pixIdx),
    .cmd    (cmd),
    .busIdx (busIdx),
    .pixWord(pixWord),
    .pixHigh(pixHigh)
  );

  palette_datapath #(
    .WORDS (WORDS),
    .WORD_W(WORD_W),
    .COMP_W(COMP_W),
    .OUT_W (OUT_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .busIdx  (busIdx),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .pixWord (pixWord),
    .pixHigh (pixHigh),
    .bgrSel  (bgrSel),
    .pixRgb  (pixRgb)
  );
endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BASE_ADDR = 32'h200,
  parameter int unsigned WORDS     = 128,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned COMP_W    = 5,
  parameter int unsigned OUT_W     = 8,
  localparam int unsigned PIX_W    = $clog2(WORDS) + 1,
  localparam int unsigned SHIFT    = OUT_W - COMP_W
) (
  input logic               clk,
  input logic               rst,
  input logic               busWr,
  input logic               busRd,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [WORD_W-1:0]  busRdata,
  input logic [PIX_W-1:0]   pixIdx,
  input logic               bgrSel,
  input logic [3*OUT_W-1:0] pixRgb
);
  logic [1:0] seen;
  logic       outside;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  assign outside = (int'(busAddr) < int'(BASE_ADDR)) ||
                   (int'(busAddr) >= int'(BASE_ADDR + WORDS * 4));

  assert_oob_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (busRd && outside) |=> (busRdata == '0));

  for (genvar k = 0; k < 3; k++) begin : g_low
    assert_low_zero_R4: assert property (@(posedge clk) disable iff (rst)
      pixRgb[k*OUT_W +: SHIFT] == '0);
  end

  assert_swap_R6: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd3 && $past(pixIdx) == $past(pixIdx, 2) && !$past(busWr, 2) &&
     $past(bgrSel) != $past(bgrSel, 2))
    |-> (pixRgb == {$past(pixRgb[OUT_W-1:0]), $past(pixRgb[2*OUT_W-1:OUT_W]),
                    $past(pixRgb[3*OUT_W-1:2*OUT_W])}));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd3 && $past(pixIdx) == $past(pixIdx, 2) && !$past(busWr, 2) &&
     $past(bgrSel) == $past(bgrSel, 2))
    |-> (pixRgb == $past(pixRgb)));
endmodule

bind palette_lut palette_lut_chk #(
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR),
  .WORDS    (WORDS),
  .WORD_W   (WORD_W),
  .COMP_W   (COMP_W),
  .OUT_W    (OUT_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busWr   (busWr),
  .busRd   (busRd),
  .busAddr (busAddr),
  .busRdata(busRdata),
  .pixIdx  (pixIdx),
  .bgrSel  (bgrSel),
  .pixRgb  (pixRgb)
);

// File: tb/sim_palette_lut.sv
module sim_palette_lut;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  pixIdx = '0;
  logic        bgrSel = 1'b0;
  logic [23:0] pixRgb;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] shadow [128];

  always #4 clk = ~clk;

  palette_lut u0 (
    .clk(clk), .rst(rst), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pixIdx(pixIdx),
    .bgrSel(bgrSel), .pixRgb(pixRgb)
  );

  function automatic logic [23:0] expColor(input logic [31:0] w, input logic hi,
                                           input logic bgr);
    logic [15:0] e;
    logic [7:0]  r, g, b;
    e = hi ? w[31:16] : w[15:0];
    r = {e[4:0], 3'b000};
    g = {e[9:5], 3'b000};
    b = {e[14:10], 3'b000};
    return bgr ? {b, g, r} : {r, g, b};
  endfunction

  function automatic logic [31:0] pattern(input int n);
    logic [31:0] v;
    v = 32'h9E3779B9 * 32'(n + 1);
    return v ^ (32'(n) << 9);
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic lookup(input logic [7:0] idx, input logic bgr,
                        output logic [23:0] c);
    pixIdx = idx; bgrSel = bgr;
    @(negedge clk);
    c = pixRgb;
  endtask

  task automatic testReset();
    check("R9 pixRgb", 32'(pixRgb), 32'h0);
    check("R9 busRdata", busRdata, 32'h0);
  endtask

  task automatic testFillReadback();
    logic [31:0] d;
    for (int n = 0; n < 128; n++) begin
      shadow[n] = pattern(n);
      busWrite(12'(12'h200 + 4 * n), shadow[n]);
    end
    for (int n = 0; n < 128; n++) begin
      busRead(12'(12'h200 + 4 * n), d);
      check("R1 readback", d, shadow[n]);
    end
  endtask

  task automatic testLookupAll(input logic bgr);
    logic [23:0] c;
    for (int i = 0; i < 256; i++) begin
      lookup(8'(i), bgr, c);
      check(bgr ? "R6 R3 R4 swapped lookup" : "R3 R4 lookup", 32'(c),
            32'(expColor(shadow[i / 2], i[0], bgr)));
    end
  endtask

  task automatic testFields();
    logic [23:0] c;
    // low half: red=0x1F, green=0, blue=0 ; high half: red=0, green=0, blue=0x1F
    shadow[5] = {16'h7C00, 16'h001F};
    busWrite(12'h214, shadow[5]);
    lookup(8'd10, 1'b0, c);
    check("R4 red only", 32'(c), 32'hF80000);
    lookup(8'd11, 1'b0, c);
    check("R4 blue only", 32'(c), 32'h0000F8);
    lookup(8'd11, 1'b1, c);
    check("R6 blue swapped", 32'(c), 32'hF80000);
    shadow[5] = {16'h0000, 16'h03E0};
    busWrite(12'h214, shadow[5]);
    lookup(8'd10, 1'b1, c);
    check("R6 green kept", 32'(c), 32'h00F800);
  endtask

  task automatic testIntensity();
    logic [23:0] c0, c1;
    shadow[9] = {16'h8000 | 16'h4A52, 16'h4A52};
    busWrite(12'h224, shadow[9]);
    lookup(8'd18, 1'b0, c0);
    lookup(8'd19, 1'b0, c1);
    check("R5 flag clear", 32'(c0), 32'(expColor(32'h00004A52, 1'b0, 1'b0)));
    check("R5 flag set", 32'(c1), 32'(c0));
  endtask

  task automatic testWindow();
    logic [31:0] d;
    busWrite(12'h1FC, 32'hDEADBEEF);
    busWrite(12'h400, 32'hCAFEF00D);
    busWrite(12'h000, 32'h12345678);
    busRead(12'h200, d);
    check("R2 word0 untouched", d, shadow[0]);
    busRead(12'h3FC, d);
    check("R2 word127 untouched", d, shadow[127]);
    busRead(12'h1FC, d);
    check("R2 read below window", d, 32'h0);
    busRead(12'h3FC, d);
    busRead(12'h400, d);
    check("R2 read above window", d, 32'h0);
  endtask

  task automatic testSameEdge();
    logic [31:0] oldW, newW;
    logic [23:0] c;
    oldW = shadow[127];
    newW = ~oldW;
    pixIdx = 8'd254; bgrSel = 1'b0;
    busWr = 1'b1; busAddr = 12'h3FC; busWdata = newW;
    @(negedge clk);
    busWr = 1'b0;
    check("R8 old colour on same edge", 32'(pixRgb),
          32'(expColor(oldW, 1'b0, 1'b0)));
    shadow[127] = newW;
    @(negedge clk);
    check("R8 new colour next cycle", 32'(pixRgb),
          32'(expColor(newW, 1'b0, 1'b0)));
  endtask

  task automatic testLatency();
    logic [23:0] held;
    pixIdx = 8'd40; bgrSel = 1'b0;
    @(negedge clk);
    held = pixRgb;
    pixIdx = 8'd41;
    check("R7 output before edge", 32'(pixRgb), 32'(held));
    @(negedge clk);
    check("R7 one cycle latency", 32'(pixRgb),
          32'(expColor(shadow[20], 1'b1, 1'b0)));
    @(negedge clk);
    check("R7 hold steady", 32'(pixRgb),
          32'(expColor(shadow[20], 1'b1, 1'b0)));
  endtask

  task automatic testResetAgain();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 pixRgb after reset", 32'(pixRgb), 32'h0);
    check("R9 busRdata after reset", busRdata, 32'h0);
    rst = 1'b0;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    @(negedge clk);
    testFillReadback();
    testLookupAll(1'b0);
    testLookupAll(1'b1);
    testFields();
    testIntensity();
    testWindow();
    testSameEdge();
    testLatency();
    testResetAgain();
    done = 1'b1;
    finishRun();
  end
endmodule